// File: doc/BRIEF.md
# Asynchronous static RAM strobe sequencer

This block sits between a clocked host and an external asynchronous static RAM of 65,536 words by 16 bits. The RAM has two byte lanes, and all of its control pins are active low. The host issues one word-sized read or write at a time over a valid/ready handshake. It supplies a write flag, a 16-bit address, 16-bit write data and a 2-bit lane mask. The block answers every request with a one-cycle completion pulse. After a read, the captured word stays on the host read port until the next read completes.

The RAM has no clock, so each of its timing limits becomes a cycle count. The ceiling of the limit in nanoseconds divided by the clock period is taken, with a floor of one cycle. Read access, write pulse, data overlap and bus release are each held for at least that count. The data bus is split into an output value, a drive enable and an input value, so a pad ring can build the tri-state buffer.

The sequencer has six states:
- IDLE (ready high, pins parked).
- RD_ACC (read access window).
- RD_END (done pulse, bus release starts).
- WR_TURN (select and address settle while any bus release still pending drains).
- WR_PULSE (write strobe low, data driven).
- WR_END (strobe released, data held one more cycle, done pulse).

The transitions are:
- IDLE→RD_ACC on a read request.
- IDLE→WR_TURN on a write request.
- RD_ACC→RD_END when the access counter expires.
- RD_END→IDLE unconditionally.
- WR_TURN→WR_PULSE once the release counter is zero.
- WR_PULSE→WR_END when the pulse counter expires.
- WR_END→IDLE unconditionally.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, ready is high and done is low. Chip select, write strobe, output enable and both byte enables are high (inactive), and the data drive enable is low.
- R2: A request is taken only when valid and ready are both high. Ready stays low from the cycle after acceptance through the cycle that carries done. Done is high for exactly one cycle per request, and ready is high again in the cycle after done.
- R3: A read keeps chip select and output enable low, and write strobe high, for N_RD cycles. N_RD is the largest of the ceilings of the read-cycle, address-access, select-access, output-enable-access and byte-enable-access limits; it is 11 at a 5 ns clock. The data input is captured on the last of those cycles, and done follows in the next cycle with the word on the read data port.
- R4: For the whole of an access, byte enable bit 0 (data bits 7:0) is the inverse of mask bit 0, and byte enable bit 1 (data bits 15:8) is the inverse of mask bit 1. On a read, a lane whose mask bit is 0 returns zero on the read data port.
- R5: A write holds the write strobe low for N_WP cycles. N_WP is the largest of the ceilings of the write-pulse, select-to-end, address-to-end, byte-enable-to-end and data-overlap limits, and of the write-cycle count less two; it is 10 at a 5 ns clock. Drive enable is high for those N_WP cycles plus the following cycle, and the driven value is the request's write data throughout.
- R6: A write with mask 00 leaves every lane of the addressed word unchanged.
- R7: After output enable returns high, drive enable stays low for at least N_TURN cycles. N_TURN is the largest ceiling of the three output-release limits; it is 6 at a 5 ns clock. When no release is pending, drive enable rises one cycle after chip select falls.
- R8: Address, byte enables and drive value are constant while chip select stays low.
- R9: Drive enable is never high while output enable is low, and the write strobe is never low while chip select is high.
- R10: The read data port keeps its value through writes and idle time until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read word, disabled lanes zero |
| mem_addr | output | 16 | RAM address pins |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte enables, active low, bit 0 = low lane |
| mem_dq_out | output | 16 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Value sampled from the data bus |

## Verification
The bench pairs the controller with a RAM model that returns filler until 54 ns of continuous access have passed. Any capture earlier than the access window therefore shows up as a wrong word. Writes are tried with all four masks over a word whose two lanes differ, which separates a lane swap, a missing lane gate and a write that ignores the empty mask. A read followed at once by a write is set against a write issued after long idle time. The first must wait out the bus release and the second must not, so the pair distinguishes a missing turnaround from one that is always applied. The read port is checked again after a write at the extreme addresses, which catches capture logic that fires on any cycle.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_END,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_END
    } ctrl_state_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_win_timer.sv
`timescale 1ns/100ps
module sram_win_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    // R3/R5 support: an idle counter never wraps around on its own.
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> (count == '0));

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/100ps
module sram_rd_capture #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rdata[g*LANE_W +: LANE_W] <= '0;
            else if (cap_en)
                rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
        end
    end

    // R10: without a capture strobe the read word does not move.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(rdata));

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/100ps
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS   = 5,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned T_RC_NS  = 55,
    parameter int unsigned T_AA_NS  = 55,
    parameter int unsigned T_ACS_NS = 55,
    parameter int unsigned T_OE_NS  = 35,
    parameter int unsigned T_BA_NS  = 35,
    parameter int unsigned T_WC_NS  = 55,
    parameter int unsigned T_WP_NS  = 45,
    parameter int unsigned T_CW_NS  = 50,
    parameter int unsigned T_AW_NS  = 50,
    parameter int unsigned T_BW_NS  = 50,
    parameter int unsigned T_DW_NS  = 25,
    parameter int unsigned T_OHZ_NS = 30,
    parameter int unsigned T_CHZ_NS = 30,
    parameter int unsigned T_BHZ_NS = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_mask,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_cs_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_be_n,
    output logic [DATA_W-1:0]        mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_in
);

    localparam int unsigned LANES = DATA_W / LANE_W;

    localparam int unsigned N_RD = umax(umax(umax(ns_to_cyc(T_RC_NS, CLK_NS),
                                                  ns_to_cyc(T_AA_NS, CLK_NS)),
                                             umax(ns_to_cyc(T_ACS_NS, CLK_NS),
                                                  ns_to_cyc(T_OE_NS, CLK_NS))),
                                        ns_to_cyc(T_BA_NS, CLK_NS));
    localparam int unsigned N_WC = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned N_WC_PULSE = (N_WC > 2) ? N_WC - 2 : 1;
    localparam int unsigned N_WP = umax(umax(umax(ns_to_cyc(T_WP_NS, CLK_NS),
                                                  ns_to_cyc(T_CW_NS, CLK_NS)),
                                             umax(ns_to_cyc(T_AW_NS, CLK_NS),
                                                  ns_to_cyc(T_BW_NS, CLK_NS))),
                                        umax(ns_to_cyc(T_DW_NS, CLK_NS), N_WC_PULSE));
    localparam int unsigned N_TURN = umax(umax(ns_to_cyc(T_OHZ_NS, CLK_NS),
                                               ns_to_cyc(T_CHZ_NS, CLK_NS)),
                                          ns_to_cyc(T_BHZ_NS, CLK_NS));
    localparam int unsigned N_MAX = umax(umax(N_RD, N_WP), N_TURN);
    localparam int unsigned CNT_W = $clog2(N_MAX + 1);

    ctrl_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;

    logic             accept;
    logic             win_ld;
    logic [CNT_W-1:0] win_ld_val;
    logic [CNT_W-1:0] win_cnt;
    logic             win_last;
    logic             turn_ld;
    logic [CNT_W-1:0] turn_cnt;
    logic             turn_clear;
    logic             cap_en;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign win_last   = (win_cnt == CNT_W'(1));
    assign turn_clear = (turn_cnt == '0);

    // ---------------- request latch ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state and counter loads ----------------
    always_comb begin
        state_d    = state_q;
        win_ld     = 1'b0;
        win_ld_val = CNT_W'(N_RD);
        turn_ld    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_TURN;
                    end else begin
                        state_d    = ST_RD_ACC;
                        win_ld     = 1'b1;
                        win_ld_val = CNT_W'(N_RD);
                    end
                end
            end
            ST_RD_ACC: begin
                if (win_last) begin
                    state_d = ST_RD_END;
                    turn_ld = 1'b1;
                end
            end
            ST_RD_END: state_d = ST_IDLE;
            ST_WR_TURN: begin
                if (turn_clear) begin
                    state_d    = ST_WR_PULSE;
                    win_ld     = 1'b1;
                    win_ld_val = CNT_W'(N_WP);
                end
            end
            ST_WR_PULSE: begin
                if (win_last) state_d = ST_WR_END;
            end
            ST_WR_END: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- pin and host outputs ----------------
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_be_n  = '1;
        mem_dq_oe = 1'b0;
        rsp_done  = 1'b0;
        req_ready = 1'b0;
        cap_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RD_ACC: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_be_n = ~mask_q;
                cap_en   = win_last;
            end
            ST_RD_END: rsp_done = 1'b1;
            ST_WR_TURN: begin
                mem_cs_n = 1'b0;
                mem_be_n = ~mask_q;
            end
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_be_n  = ~mask_q;
                mem_dq_oe = 1'b1;
            end
            ST_WR_END: begin
                mem_be_n  = ~mask_q;
                mem_dq_oe = 1'b1;
                rsp_done  = 1'b1;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // ---------------- submodules ----------------
    sram_win_timer #(.CNT_W(CNT_W)) u_win_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_ld),
        .load_val (win_ld_val),
        .count    (win_cnt)
    );

    sram_win_timer #(.CNT_W(CNT_W)) u_turn_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (turn_ld),
        .load_val (CNT_W'(N_TURN)),
        .count    (turn_cnt)
    );

    sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .lane_en (mask_q),
        .din     (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    // ---------------- assertions ----------------
    a_r9_drive_needs_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r9_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r2_ready_parked: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_dq_oe && mem_we_n));

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    a_r7_turn_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !$past(mem_dq_oe)) |-> (turn_cnt == '0));

    a_r3_read_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_oe_n) && mem_oe_n) |-> rsp_done);

endmodule

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/100ps
module sram_bus_ctrl_tb_top;

    localparam int unsigned CLK_NS = 5;

    function automatic int unsigned cyc(input int unsigned ns);
        int unsigned c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        if (c == 0) c = 1;
        return c;
    endfunction

    // Expected counts from the requirements at the default limits.
    localparam int unsigned E_RD   = cyc(55);
    localparam int unsigned E_WP   = cyc(50);
    localparam int unsigned E_TURN = cyc(30);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic rsp_done;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic mem_cs_n, mem_we_n, mem_oe_n;
    logic [1:0] mem_be_n;
    logic [15:0] mem_dq_out;
    logic mem_dq_oe;
    logic [15:0] mem_dq_in = 16'h3C3C;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_bus_ctrl #(.CLK_NS(CLK_NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- RAM model ----------------
    logic [15:0] mem [int unsigned];

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 16'h0000;
    endfunction

    realtime t0 = 0.0;
    bit act_prev = 0;
    logic [15:0] addr_seen = '0;

    initial begin
        #0.2;
        forever begin
            bit act;
            logic [15:0] v;
            act = !mem_cs_n && !mem_oe_n && mem_we_n;
            if (act && (!act_prev || mem_addr != addr_seen)) t0 = $realtime;
            act_prev  = act;
            addr_seen = mem_addr;
            if (!act)
                mem_dq_in = 16'h3C3C;
            else if ($realtime - t0 < 54.0)
                mem_dq_in = 16'hC3C3;
            else begin
                v = mem_rd(mem_addr);
                mem_dq_in = {mem_be_n[1] ? 8'h5A : v[15:8], mem_be_n[0] ? 8'h5A : v[7:0]};
            end
            #0.5;
        end
    end

    // Write commit, contention, address and turnaround monitors.
    bit pend = 0;
    logic [15:0] p_addr, p_data;
    logic [1:0]  p_be;
    bit contention = 0, undriven_wr = 0, addr_moved = 0;
    bit cs_prev_low = 0;
    logic [15:0] addr_prev = '0;
    bit oe_prev = 1, gap_run = 0;
    int gap = 0, last_gap = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && !mem_cs_n) begin
                pend = 1; p_addr = mem_addr; p_data = mem_dq_out; p_be = mem_be_n;
                if (!mem_dq_oe) undriven_wr = 1;
            end else if (pend) begin
                logic [15:0] o;
                o = mem_rd(p_addr);
                if (!p_be[0]) o[7:0]  = p_data[7:0];
                if (!p_be[1]) o[15:8] = p_data[15:8];
                mem[int'(p_addr)] = o;
                pend = 0;
            end
            if (mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n) contention = 1;
            if (!mem_cs_n && cs_prev_low && mem_addr != addr_prev) addr_moved = 1;
            cs_prev_low = !mem_cs_n;
            addr_prev   = mem_addr;
            if (!oe_prev && mem_oe_n) begin gap_run = 1; gap = 0; end
            if (gap_run) begin
                if (mem_dq_oe) begin last_gap = gap; gap_run = 0; end
                else gap++;
            end
            oe_prev = mem_oe_n;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    // Issue one request and measure the strobe shape.
    task automatic run_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           input logic [1:0] m,
                           output int oe_c, output int we_c, output int drv_c,
                           output int lead, output bit be_ok, output bit busy_ok,
                           output bit post_ok);
        int guard;
        oe_c = 0; we_c = 0; drv_c = 0; lead = 0; be_ok = 1; busy_ok = 1; post_ok = 1;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
        guard = 0;
        forever begin
            if (!mem_oe_n) oe_c++;
            if (!mem_we_n) we_c++;
            if (mem_dq_oe) drv_c++;
            if (!mem_cs_n && mem_we_n && !mem_dq_oe && wr) lead++;
            if ((!mem_cs_n || mem_dq_oe) && mem_be_n != ~m) be_ok = 0;
            if (rsp_done) break;
            if (req_ready) busy_ok = 0;
            guard++;
            if (guard > 200) break;
            @(negedge clk);
        end
        @(negedge clk);
        if (rsp_done || !req_ready) post_ok = 0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        int oe_c, we_c, drv_c, lead; bit be_ok, busy_ok, post_ok;
        run_req(1, a, d, m, oe_c, we_c, drv_c, lead, be_ok, busy_ok, post_ok);
        chk(we_c == E_WP, "R5", "write strobe cycles", we_c, E_WP);
        chk(drv_c == E_WP + 1, "R5", "drive cycles", drv_c, E_WP + 1);
        chk(be_ok, "R4", "byte enables vs mask on write", {30'd0, m}, {30'd0, m});
        chk(busy_ok && post_ok, "R2", "ready/done shape on write", {busy_ok, post_ok}, 2'b11);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] m, input logic [15:0] expv);
        int oe_c, we_c, drv_c, lead; bit be_ok, busy_ok, post_ok;
        run_req(0, a, 16'h0, m, oe_c, we_c, drv_c, lead, be_ok, busy_ok, post_ok);
        chk(oe_c == E_RD, "R3", "output enable cycles", oe_c, E_RD);
        chk(rsp_rdata == expv, "R3", "read word", rsp_rdata, expv);
        chk(be_ok, "R4", "byte enables vs mask on read", {30'd0, m}, {30'd0, m});
        chk(busy_ok && post_ok, "R2", "ready/done shape on read", {busy_ok, post_ok}, 2'b11);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready && !rsp_done, "R1", "ready/done in reset", {req_ready, rsp_done}, 2'b10);
        chk({mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe} == 6'b111110, "R1",
            "pins in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_done && mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11
            && !mem_dq_oe, "R1", "pins after reset", {req_ready, mem_cs_n}, 2'b11);
    endtask

    task automatic t_basic();
        do_write(16'h1234, 16'hBEEF, 2'b11);
        do_read(16'h1234, 2'b11, 16'hBEEF);
    endtask

    task automatic t_turnaround();
        int oe_c, we_c, drv_c, lead; bit be_ok, busy_ok, post_ok;
        do_read(16'h1234, 2'b11, 16'hBEEF);
        do_write(16'h2000, 16'h0F0F, 2'b11);
        chk(last_gap >= int'(E_TURN), "R7", "release cycles after read", last_gap, E_TURN);
        repeat (12) @(negedge clk);
        run_req(1, 16'h2001, 16'hF0F0, 2'b11, oe_c, we_c, drv_c, lead, be_ok, busy_ok, post_ok);
        chk(lead == 1, "R7", "drive lead after idle", lead, 1);
    endtask

    task automatic t_lanes();
        do_write(16'h0001, 16'h1122, 2'b11);
        do_write(16'h0001, 16'hFFEE, 2'b01);
        do_read(16'h0001, 2'b11, 16'h11EE);
        do_write(16'h0001, 16'h7788, 2'b10);
        do_read(16'h0001, 2'b10, 16'h7700);
        do_read(16'h0001, 2'b01, 16'h00EE);
    endtask

    task automatic t_null_mask();
        do_write(16'h0001, 16'hDEAD, 2'b00);
        do_read(16'h0001, 2'b11, 16'h77EE);
        chk(rsp_rdata == 16'h77EE, "R6", "word after empty-mask write", rsp_rdata, 16'h77EE);
    endtask

    task automatic t_hold_and_edges();
        do_write(16'hFFFF, 16'hCAFE, 2'b11);
        do_read(16'hFFFF, 2'b11, 16'hCAFE);
        do_write(16'h0000, 16'h0101, 2'b11);
        repeat (5) @(negedge clk);
        chk(rsp_rdata == 16'hCAFE, "R10", "read port after write", rsp_rdata, 16'hCAFE);
        do_read(16'h0000, 2'b11, 16'h0101);
    endtask

    task automatic t_monitors();
        chk(!contention, "R9", "bus driven while RAM outputs on", contention, 0);
        chk(!addr_moved, "R8", "address moved under select", addr_moved, 0);
        chk(!undriven_wr, "R5", "strobe low without drive", undriven_wr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_turnaround();
        t_lanes();
        t_null_mask();
        t_hold_and_edges();
        t_monitors();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nvec++; nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule